// File: doc/BRIEF.md
# Per-Hop Interrupt Notify Aggregator

This block gathers three kinds of per-hop event into a single status vector that software reads through a 32-bit register port. The three kinds are transmit completion, receive completion and receive overflow. Each hop contributes one bit to each of three fields. The fields are concatenated and spread across as many 32-bit status words as they need. Reading a status word returns its contents and clears it. A separate set of enable words gates, per hop, whether transmit or receive activity may raise the interrupt line.

The interrupt is a single-cycle pulse. After a pulse, the block stays quiet until software has read every status word at least once. This includes words whose bits belong only to hops with interrupts turned off. Only then may a pulse fire again, so software must sweep the whole status array. A read-only register reports how many hops the instance was built with.

Top module: `hop_irq_collector`

## Requirements
- R1: A transmit event on hop h sets combined status bit h, a receive event sets bit HOPS+h, and an overflow event sets bit 2·HOPS+h. Combined bit k appears in bit k mod 32 of the status word at address STAT_BASE + k/32.
- R2: There are (31 + 3·HOPS)/32 status words (integer division). Bits of the last word above bit 3·HOPS−1 always read as zero.
- R3: A read presents its data on rdata_o in the cycle after rd_en_i. Reading a status word returns its contents and clears every bit in it.
- R4: An event that arrives in the same cycle as a read of its status word is absent from that read's data and present in the following read of that word.
- R5: The enable vector has (31 + 2·HOPS)/32 words at addresses EN_BASE onward. Bit h enables receive-side interrupts of hop h, and bit HOPS+h enables transmit interrupts of hop h. The words are written by wr_en_i and read back, and unused top bits read as zero.
- R6: irq_o pulses high for exactly one cycle, one cycle after the block is armed and some status bit is pending with its enable set. Transmit bits are gated by the transmit enable. Receive and overflow bits are gated by the receive enable of their hop.
- R7: After a pulse, no further pulse occurs until every status word has been read at least once since the pulse, including words that cover only disabled hops. Once the last unread word is read, a still-pending enabled bit fires again.
- R8: The hop-count register at address HOPCNT_ADDR reads HOPS in bits 10:0, with all higher bits zero.
- R9: Writes to status words or to the hop-count register change nothing that a later read observes.
- R10: After reset all status and enable bits are zero, irq_o is low and the block is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_evt_i | input | HOPS | Transmit-completion events, one per hop, one cycle each |
| rx_evt_i | input | HOPS | Receive-completion events, one per hop |
| ovf_evt_i | input | HOPS | Receive-overflow events, one per hop |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The checker treats each event input as a one-cycle strobe. It relies on reads of the last status word, enable word and hop-count register being the only source of what it checks in rdata_o a cycle later. It also takes for granted that read and write strobes never land on the same cycle. The bench drives every strobe for one cycle from the falling edge and never overlaps a read with a write. It addresses only mapped words, except for the deliberate writes to read-only locations.

// File: rtl/hic_pkg.sv
package hic_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned HOPCNT_W = 11;

   typedef logic [WORD_W-1:0] word_t;

   function automatic int unsigned words_for(input int unsigned nbits);
      return (nbits + WORD_W - 1) / WORD_W;
   endfunction
endpackage

// File: rtl/hic_status_bank.sv
module hic_status_bank #(
   parameter int unsigned HOPS   = 12,
   parameter int unsigned NWORDS = 2
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [HOPS-1:0]                    tx_evt,
   input  logic [HOPS-1:0]                    rx_evt,
   input  logic [HOPS-1:0]                    ovf_evt,
   input  logic [NWORDS-1:0]                  clr_word,
   output logic [3*HOPS-1:0]                  stat_vec,
   output logic [NWORDS*hic_pkg::WORD_W-1:0]  stat_flat
);
   localparam int unsigned NBITS = 3 * HOPS;
   localparam int unsigned PAD   = NWORDS * hic_pkg::WORD_W - NBITS;

   logic [NBITS-1:0] evt_vec;
   logic [NBITS-1:0] stat_q;

   assign evt_vec = {ovf_evt, rx_evt, tx_evt};

   // each bit: clear by its word's read first, then merge this cycle's event
   for (genvar k = 0; k < NBITS; k++) begin : g_bit
      localparam int unsigned WI = k / hic_pkg::WORD_W;
      always_ff @(posedge clk) begin
         if (!rst_n) stat_q[k] <= 1'b0;
         else        stat_q[k] <= (stat_q[k] & ~clr_word[WI]) | evt_vec[k];
      end
   end

   assign stat_vec = stat_q;

   if (PAD > 0) begin : g_pad
      assign stat_flat = {{PAD{1'b0}}, stat_q};
   end else begin : g_nopad
      assign stat_flat = stat_q;
   end
endmodule

// File: rtl/hic_enable_bank.sv
module hic_enable_bank #(
   parameter int unsigned HOPS   = 12,
   parameter int unsigned NWORDS = 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NWORDS-1:0]                  wr_word,
   input  hic_pkg::word_t                     wdata,
   output logic [2*HOPS-1:0]                  en_vec,
   output logic [NWORDS*hic_pkg::WORD_W-1:0]  en_flat
);
   localparam int unsigned NBITS = 2 * HOPS;
   localparam int unsigned PAD   = NWORDS * hic_pkg::WORD_W - NBITS;

   logic [NBITS-1:0] en_q;

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam int unsigned LO = w * hic_pkg::WORD_W;
      localparam int unsigned HI = ((LO + hic_pkg::WORD_W) < NBITS) ?
                                   (LO + hic_pkg::WORD_W - 1) : (NBITS - 1);
      always_ff @(posedge clk) begin
         if (!rst_n)          en_q[HI:LO] <= '0;
         else if (wr_word[w]) en_q[HI:LO] <= wdata[HI-LO:0];
      end
   end

   assign en_vec = en_q;

   if (PAD > 0) begin : g_pad
      assign en_flat = {{PAD{1'b0}}, en_q};
   end else begin : g_nopad
      assign en_flat = en_q;
   end
endmodule

// File: rtl/hic_arm_ctrl.sv
module hic_arm_ctrl #(
   parameter int unsigned NWORDS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NWORDS-1:0] rd_word,
   input  logic              pend_any,
   output logic              armed,
   output logic              irq
);
   logic [NWORDS-1:0] seen_q;
   logic [NWORDS-1:0] seen_nxt;
   logic              armed_q;
   logic              irq_q;
   logic              fire;

   assign seen_nxt = seen_q | rd_word;
   assign fire     = armed_q & pend_any;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         seen_q  <= '0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= fire;
         if (fire) begin
            armed_q <= 1'b0;
            seen_q  <= '0;
         end else if (!armed_q) begin
            if (&seen_nxt) begin
               armed_q <= 1'b1;
               seen_q  <= '0;
            end else begin
               seen_q  <= seen_nxt;
            end
         end
      end
   end

   assign armed = armed_q;
   assign irq   = irq_q;
endmodule

// File: rtl/hop_irq_collector.sv
module hop_irq_collector #(
   parameter int unsigned HOPS          = 12,
   parameter int unsigned ADDR_W        = 6,
   parameter int unsigned STAT_BASE     = 0,
   parameter int unsigned EN_BASE       = 16,
   parameter int unsigned HOPCNT_ADDR   = 32,
   parameter bit          OVF_BY_RX_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HOPS-1:0]   tx_evt_i,
   input  logic [HOPS-1:0]   rx_evt_i,
   input  logic [HOPS-1:0]   ovf_evt_i,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              irq_o
);
   import hic_pkg::*;

   localparam int unsigned STAT_WORDS = words_for(3 * HOPS);
   localparam int unsigned EN_WORDS   = words_for(2 * HOPS);
   localparam int unsigned MAP_SIZE   = 1 << ADDR_W;

   if (HOPS < 1 || HOPS >= (1 << HOPCNT_W)) begin : g_bad_hops
      $error("HOPS must fit the hop-count field");
   end
   if (STAT_BASE + STAT_WORDS > EN_BASE) begin : g_bad_stat
      $error("status words overlap enable words");
   end
   if (EN_BASE + EN_WORDS > HOPCNT_ADDR) begin : g_bad_en
      $error("enable words overlap hop-count register");
   end
   if (HOPCNT_ADDR >= MAP_SIZE) begin : g_bad_addr
      $error("hop-count register outside address space");
   end

   logic [STAT_WORDS-1:0]        rd_word;
   logic [EN_WORDS-1:0]          wr_word;
   logic [3*HOPS-1:0]            stat_vec;
   logic [STAT_WORDS*WORD_W-1:0] stat_flat;
   logic [2*HOPS-1:0]            en_vec;
   logic [EN_WORDS*WORD_W-1:0]   en_flat;
   logic [HOPS-1:0]              tx_hit, rx_hit, ovf_hit;
   logic                         pend_any;
   logic                         armed;
   word_t                        rsel;
   word_t                        rdata_q;

   for (genvar w = 0; w < STAT_WORDS; w++) begin : g_rd
      assign rd_word[w] = rd_en_i && (addr_i == ADDR_W'(STAT_BASE + w));
   end
   for (genvar w = 0; w < EN_WORDS; w++) begin : g_wr
      assign wr_word[w] = wr_en_i && (addr_i == ADDR_W'(EN_BASE + w));
   end

   hic_status_bank #(.HOPS(HOPS), .NWORDS(STAT_WORDS)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_evt    (tx_evt_i),
      .rx_evt    (rx_evt_i),
      .ovf_evt   (ovf_evt_i),
      .clr_word  (rd_word),
      .stat_vec  (stat_vec),
      .stat_flat (stat_flat)
   );

   hic_enable_bank #(.HOPS(HOPS), .NWORDS(EN_WORDS)) u_enable (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_word (wr_word),
      .wdata   (wdata_i),
      .en_vec  (en_vec),
      .en_flat (en_flat)
   );

   // receive enables occupy the low field, transmit enables the high field
   assign tx_hit = stat_vec[HOPS-1:0]      & en_vec[2*HOPS-1:HOPS];
   assign rx_hit = stat_vec[2*HOPS-1:HOPS] & en_vec[HOPS-1:0];

   if (OVF_BY_RX_EN) begin : g_ovf_gated
      assign ovf_hit = stat_vec[3*HOPS-1:2*HOPS] & en_vec[HOPS-1:0];
   end else begin : g_ovf_free
      assign ovf_hit = stat_vec[3*HOPS-1:2*HOPS];
   end

   assign pend_any = |{tx_hit, rx_hit, ovf_hit};

   hic_arm_ctrl #(.NWORDS(STAT_WORDS)) u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_word  (rd_word),
      .pend_any (pend_any),
      .armed    (armed),
      .irq      (irq_o)
   );

   always_comb begin
      rsel = '0;
      for (int w = 0; w < STAT_WORDS; w++) begin
         if (addr_i == ADDR_W'(STAT_BASE + w)) rsel = stat_flat[w*WORD_W +: WORD_W];
      end
      for (int w = 0; w < EN_WORDS; w++) begin
         if (addr_i == ADDR_W'(EN_BASE + w)) rsel = en_flat[w*WORD_W +: WORD_W];
      end
      if (addr_i == ADDR_W'(HOPCNT_ADDR)) rsel = {{(WORD_W-HOPCNT_W){1'b0}}, HOPCNT_W'(HOPS)};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata_q <= '0;
      else if (rd_en_i) rdata_q <= rsel;
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/hic_checker.sv
module hic_checker #(
   parameter int unsigned HOPS        = 12,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned STAT_BASE   = 0,
   parameter int unsigned EN_BASE     = 16,
   parameter int unsigned HOPCNT_ADDR = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [31:0]       rdata_o,
   input logic              irq_o,
   input logic              pend_any,
   input logic              armed
);
   localparam int unsigned STAT_WORDS = hic_pkg::words_for(3 * HOPS);
   localparam int unsigned EN_WORDS   = hic_pkg::words_for(2 * HOPS);
   localparam int unsigned STAT_REM   = (3 * HOPS) % 32;
   localparam int unsigned EN_REM     = (2 * HOPS) % 32;
   localparam logic [ADDR_W-1:0] STAT_LAST = ADDR_W'(STAT_BASE + STAT_WORDS - 1);
   localparam logic [ADDR_W-1:0] EN_LAST   = ADDR_W'(EN_BASE + EN_WORDS - 1);
   localparam logic [ADDR_W-1:0] HC_ADDR   = ADDR_W'(HOPCNT_ADDR);

   assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(pend_any));

   assert_disarm_on_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !armed);

   assert_hopcnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && addr_i == HC_ADDR) |=> (rdata_o == 32'(HOPS)));

   if (STAT_REM != 0) begin : g_stat_pad
      assert_stat_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en_i && addr_i == STAT_LAST) |=> (rdata_o[31:STAT_REM] == '0));
   end
   if (EN_REM != 0) begin : g_en_pad
      assert_en_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en_i && addr_i == EN_LAST) |=> (rdata_o[31:EN_REM] == '0));
   end
endmodule

bind hop_irq_collector hic_checker #(
   .HOPS(HOPS), .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE),
   .EN_BASE(EN_BASE), .HOPCNT_ADDR(HOPCNT_ADDR)
) u_hic_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en_i  (rd_en_i),
   .addr_i   (addr_i),
   .rdata_o  (rdata_o),
   .irq_o    (irq_o),
   .pend_any (pend_any),
   .armed    (armed)
);

// File: tb/hop_irq_collector_bench.sv
`timescale 1ns/1ps
module hop_irq_collector_bench;
   localparam int HOPS   = 12;
   localparam int ADDR_W = 6;
   localparam int SBASE  = 0;
   localparam int EBASE  = 16;
   localparam int HCADDR = 32;
   localparam int SWORDS = (31 + 3*HOPS) / 32;
   localparam int EWORDS = (31 + 2*HOPS) / 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [HOPS-1:0]   tx_evt = '0, rx_evt = '0, ovf_evt = '0;
   logic              rd_en = 1'b0, wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic              irq;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;

   always #2 clk = ~clk;

   hop_irq_collector u_hop_irq_collector (
      .clk(clk), .rst_n(rst_n),
      .tx_evt_i(tx_evt), .rx_evt_i(rx_evt), .ovf_evt_i(ovf_evt),
      .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = ADDR_W'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input int kind, input int h);
      @(negedge clk);
      if (kind == 0) tx_evt[h] = 1'b1;
      else if (kind == 1) rx_evt[h] = 1'b1;
      else ovf_evt[h] = 1'b1;
      @(negedge clk);
      tx_evt = '0; rx_evt = '0; ovf_evt = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_all_discard();
      logic [31:0] d;
      for (int w = 0; w < SWORDS; w++) rd(SBASE + w, d);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      logic [63:0] env;
      int base_cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      chk(irq == 1'b0, "R10 irq low", {31'b0, irq}, 32'h0);
      for (int w = 0; w < SWORDS; w++) begin
         rd(SBASE + w, d);
         chk(d == 0, "R10 status zero", d, 32'h0);
      end
      for (int w = 0; w < EWORDS; w++) begin
         rd(EBASE + w, d);
         chk(d == 0, "R10 enable zero", d, 32'h0);
      end

      // R8 hop count, R9 write to it ignored
      rd(HCADDR, d);
      chk(d == 32'(HOPS), "R8 hop count", d, 32'(HOPS));
      wr(HCADDR, 32'hFFFF_FFFF);
      rd(HCADDR, d);
      chk(d == 32'(HOPS), "R9 hop count write ignored", d, 32'(HOPS));

      // R5 enable readback sweep
      for (int p = 0; p < 4; p++) begin
         logic [31:0] pat;
         logic [31:0] expv;
         pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5A5_A5A5 :
               (p == 2) ? 32'h5A5A_5A5A : 32'h0000_0001;
         expv = pat & ((32'h1 << (2*HOPS)) - 1);
         wr(EBASE, pat);
         rd(EBASE, d);
         chk(d == expv, "R5 enable readback", d, expv);
      end
      wr(EBASE, 32'h0);

      // R1 R2 R3 R6 sweep: every hop, every kind, every enable mode
      for (int h = 0; h < HOPS; h++) begin
         for (int t = 0; t < 3; t++) begin
            for (int m = 0; m < 4; m++) begin
               int k;
               bit rx_on, tx_on, exp_irq;
               rx_on = m[0];
               tx_on = m[1];
               env = '0;
               if (rx_on) env[h] = 1'b1;
               if (tx_on) env[HOPS+h] = 1'b1;
               for (int w = 0; w < EWORDS; w++) wr(EBASE + w, env[w*32 +: 32]);
               base_cnt = irq_cnt;
               pulse(t, h);
               idle(3);
               exp_irq = (t == 0) ? tx_on : rx_on;
               chk((irq_cnt - base_cnt) == int'(exp_irq), "R6 gating by enable",
                   32'(irq_cnt - base_cnt), 32'(exp_irq));
               k = t*HOPS + h;
               for (int w = 0; w < SWORDS; w++) begin
                  logic [31:0] e;
                  e = (k / 32 == w) ? (32'h1 << (k % 32)) : 32'h0;
                  rd(SBASE + w, d);
                  chk(d == e, "R1 status bit position", d, e);
               end
               for (int w = 0; w < SWORDS; w++) begin
                  rd(SBASE + w, d);
                  chk(d == 0, "R3 cleared after read", d, 32'h0);
               end
            end
         end
      end

      // R2 padding of last status word with all events set
      @(negedge clk);
      tx_evt = '1; rx_evt = '1; ovf_evt = '1;
      @(negedge clk);
      tx_evt = '0; rx_evt = '0; ovf_evt = '0;
      rd(SBASE + SWORDS - 1, d);
      chk(d == ((32'h1 << ((3*HOPS) % 32)) - 1), "R2 last word padding zero",
          d, (32'h1 << ((3*HOPS) % 32)) - 1);
      read_all_discard();

      // R4 event coincident with read of its word
      wr(EBASE, 32'h0);
      @(negedge clk);
      rd_en = 1'b1; addr = ADDR_W'(SBASE); tx_evt[2] = 1'b1;
      @(negedge clk);
      rd_en = 1'b0; tx_evt = '0;
      d = rdata;
      chk(d[2] == 1'b0, "R4 not in coincident read", d, 32'h0);
      rd(SBASE, d);
      chk(d == 32'h4, "R4 kept for next read", d, 32'h4);

      // R9 write to status word ignored
      pulse(0, 0);
      wr(SBASE, 32'h0);
      rd(SBASE, d);
      chk(d == 32'h1, "R9 status write ignored", d, 32'h1);

      // R6 exact pulse timing
      wr(EBASE, 32'hFFFF_FFFF);
      @(negedge clk);
      tx_evt[3] = 1'b1;
      @(negedge clk);
      tx_evt = '0;
      chk(irq == 1'b0, "R6 no pulse in event-capture cycle", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk(irq == 1'b1, "R6 pulse one cycle after pending", {31'b0, irq}, 32'h1);
      @(negedge clk);
      chk(irq == 1'b0, "R6 pulse lasts one cycle", {31'b0, irq}, 32'h0);

      // R7 rearm needs every word, including one holding only disabled hops
      wr(EBASE, 32'h0000_F000);   // transmit enables of hops 0..3 only
      base_cnt = irq_cnt;
      rd(SBASE, d);               // word 0 only
      pulse(0, 3);
      idle(4);
      chk(irq_cnt == base_cnt, "R7 quiet before all words read",
          32'(irq_cnt - base_cnt), 32'h0);
      rd(SBASE + 1, d);           // word covering only disabled overflow bits
      idle(3);
      chk(irq_cnt == base_cnt + 1, "R7 fires once all words read",
          32'(irq_cnt - base_cnt), 32'h1);
      read_all_discard();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule